// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that gives a host processor access to five 8-bit registers through a two-wire bus. The system clock samples SCL and SDA, so the block needs no second clock domain. The block answers one fixed 7-bit device address. It pulls SDA low through an open-drain enable output and never drives the line high.

In a write transfer, the first data byte after the address selects a register. Each later data byte writes the selected register, and the selection then moves to the next register. A read transfer returns the register at the current selection and then moves the selection forward. The host can therefore set the selection with a short write, then read a run of registers after a repeated START.

The only writable register is the LED byte, and it drives the `led_o` output. The other registers are:
- a boot-variant constant;
- two revision constants;
- a status byte assembled from live input pins.

Top module: `i2c_rb_top`

## Requirements
- R1: After reset, `led_o` is 0x01 and `sda_oe_o` is 0, so SDA is released.
- R2: The block acknowledges only the address byte whose upper seven bits are 0x30, meaning 0x60 for a write and 0x61 for a read. For any other address it acknowledges nothing and changes nothing until the next START.
- R3: In a write transfer, the first data byte loads the register index. Each following data byte writes the indexed register, and the index then increases by one. The index stays in effect for later transfers.
- R4: Index 0x00 is the LED byte. A host write to it appears on `led_o`, and a read returns its value.
- R5: Index 0x01 reads 0x01, the boot variant. Indexes 0x02 and 0x03 read 0x03, the firmware and board revisions. All three are read-only.
- R6: Index 0x04 reads the status byte: bit 4 is `irq_i`, bits 3:0 are `mode_i[3:0]`, and bits 7:5 are 0. The byte follows the live pins.
- R7: Each byte sent in a read transfer comes from the current index, and the index then increases by one. After the master answers a byte with NACK, the block releases SDA and does not drive it again until a new START.
- R8: A data byte written to a read-only index, or to any index above 0x04, is acknowledged and has no effect. A read at an index above 0x04 returns 0x00.
- R9: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Either one aborts a byte in progress, and a repeated START begins a new address phase.
- R10: The block changes `sda_oe_o` only while SCL is low. An acknowledge holds SDA low for the entire high phase of the ninth clock, and a read data bit stays constant for its entire high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (the wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| led_o | output | 8 | LED register contents |
| irq_i | input | 1 | Interrupt pin, shown on status bit 4 |
| mode_i | input | 4 | Mode pins, shown on status bits 3:0 |

## Verification
The assertions take for granted a well-behaved single master with the following properties:
- SCL low and high phases last many system clocks, well beyond the synchronizer delay.
- SDA changes only while SCL is low, except to form START and STOP.
- A STOP never arrives while the target itself is holding SDA low.

The bench's bus tasks keep every phase 20 to 40 system clocks long. They move SDA a quarter-period after SCL falls, and they issue STOP or repeated START only after the target has released the line. The status pins are changed only between transfers.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } rb_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned MODE_W = 4;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_V[g]}};
      else     pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              active
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rb_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic              first;
  logic              nack;
  logic              byte_end;

  assign byte_end = scl_fall && (cnt == FULL);
  assign wr_en    = (state == ST_WDATA) && byte_end && !first && !start_p && !stop_p;
  assign wr_data  = sh;
  assign active   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      nack   <= 1'b0;
      idx    <= '0;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise && cnt < FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              first  <= 1'b1;
              state  <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              idx    <= idx + 1'b1;
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise && cnt < FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            sda_oe <= 1'b1;
            state  <= ST_WACK;
            if (first) begin
              idx   <= sh;
              first <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && cnt < FULL) begin
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else if (scl_fall && cnt != '0) begin
            sh     <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_IDLE;
            end else begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              idx    <= idx + 1'b1;
              cnt    <= '0;
              state  <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LED_RST   = 8'h01,
  parameter logic [BYTE_W-1:0] BOOT_VAR  = 8'h01,
  parameter logic [BYTE_W-1:0] FW_REV    = 8'h03,
  parameter logic [BYTE_W-1:0] BOARD_REV = 8'h03,
  parameter int unsigned       STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              irq_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] led_o
);
  localparam int unsigned PIN_W = MODE_W + 1;

  logic [PIN_W-1:0]  pins_s;
  logic [BYTE_W-1:0] status;

  i2c_rb_sync #(.W(PIN_W), .STAGES(STAGES), .RST_V('0)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .din ({irq_i, mode_i}),
    .dout(pins_s)
  );

  assign status = {{(BYTE_W-PIN_W){1'b0}}, pins_s};

  always_ff @(posedge clk) begin
    if (rst)                        led_o <= LED_RST;
    else if (wr_en && idx == 8'h00) led_o <= wr_data;
  end

  always_comb begin
    case (idx)
      8'h00:   rd_data = led_o;
      8'h01:   rd_data = BOOT_VAR;
      8'h02:   rd_data = FW_REV;
      8'h03:   rd_data = BOARD_REV;
      8'h04:   rd_data = status;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/i2c_rb_top.sv
module i2c_rb_top
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h30,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] LED_RST     = 8'h01,
  parameter logic [BYTE_W-1:0] BOOT_VAR    = 8'h01,
  parameter logic [BYTE_W-1:0] FW_REV      = 8'h03,
  parameter logic [BYTE_W-1:0] BOARD_REV   = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] led_o,
  input  logic              irq_i,
  input  logic [MODE_W-1:0] mode_i
);
  logic              scl_s, sda_s, scl_p, sda_p;
  logic              scl_rise, scl_fall, start_p, stop_p;
  logic [IDX_W-1:0]  idx;
  logic              wr_en, eng_active;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_rb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(2'b11)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout({scl_s, sda_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;

  i2c_rb_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rd_data (rd_data),
    .idx     (idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sda_oe  (sda_oe_o),
    .active  (eng_active)
  );

  i2c_rb_regs #(
    .LED_RST  (LED_RST),
    .BOOT_VAR (BOOT_VAR),
    .FW_REV   (FW_REV),
    .BOARD_REV(BOARD_REV),
    .STAGES   (SYNC_STAGES)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .idx    (idx),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .irq_i  (irq_i),
    .mode_i (mode_i),
    .rd_data(rd_data),
    .led_o  (led_o)
  );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk #(
  parameter logic [7:0] LED_RST = 8'h01
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       stop_p,
  input logic       sda_oe,
  input logic       active,
  input logic [7:0] led_o
);
  // R1
  led_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (led_o == LED_RST && !sda_oe));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_oe);

  // R4
  led_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(led_o) |-> $past(scl_fall));

  // R2
  oe_active_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> active);
endmodule

bind i2c_rb_top i2c_rb_chk #(.LED_RST(LED_RST)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_s   (scl_s),
  .scl_fall(scl_fall),
  .stop_p  (stop_p),
  .sda_oe  (sda_oe_o),
  .active  (eng_active),
  .led_o   (led_o)
);

// File: tb/sim_i2c_rb_top.sv
`timescale 1ns/1ps
module sim_i2c_rb_top;
  localparam int Q = 20;
  localparam int H = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       irq = 1'b0;
  logic [3:0] mode = 4'h0;
  logic       sda_oe;
  logic [7:0] led;
  wire        sda = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_rb_top u0 (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (sda),
    .sda_oe_o(sda_oe),
    .led_o   (led),
    .irq_i   (irq),
    .mode_i  (mode)
  );

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitn(Q);
    scl = 1'b1;   waitn(Q);
    m_sda = 1'b0; waitn(Q);
    scl = 1'b0;   waitn(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitn(Q);
    scl = 1'b1;   waitn(Q);
    m_sda = 1'b1; waitn(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;  waitn(Q);
    scl = 1'b1; waitn(H);
    scl = 1'b0; waitn(Q);
  endtask

  // Sends a byte, returns 1 when SDA was held low through the whole ninth high phase.
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a0, a1;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    m_sda = 1'b1; waitn(Q);
    scl = 1'b1; waitn(2); a0 = sda;
    waitn(H - 4); a1 = sda; waitn(2);
    scl = 1'b0; waitn(Q);
    ack = !a0 && !a1;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d, output logic stable_ok);
    logic b0, b1;
    stable_ok = 1'b1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitn(Q);
      scl = 1'b1; waitn(2); b0 = sda;
      waitn(H - 4); b1 = sda; waitn(2);
      scl = 1'b0; waitn(Q);
      d[i] = b0;
      if (b0 !== b1) stable_ok = 1'b0;
    end
    send_bit(!give_ack);
    m_sda = 1'b1;
  endtask

  task automatic write_regs(input logic [7:0] ix, input logic [7:0] d[], input string req);
    logic ack;
    bus_start();
    wbyte(8'h60, ack); chk({req, " addr ack"}, 8'(ack), 8'h01);
    wbyte(ix, ack);    chk({req, " index ack"}, 8'(ack), 8'h01);
    foreach (d[k]) begin
      wbyte(d[k], ack); chk({req, " data ack"}, 8'(ack), 8'h01);
    end
    bus_stop();
  endtask

  task automatic read_from(input logic [7:0] ix, input logic [7:0] exp[], input string req);
    logic ack, st;
    logic [7:0] d;
    bus_start();
    wbyte(8'h60, ack); chk({req, " addr ack"}, 8'(ack), 8'h01);
    wbyte(ix, ack);    chk({req, " index ack"}, 8'(ack), 8'h01);
    bus_start();
    wbyte(8'h61, ack); chk({req, " read addr ack R9"}, 8'(ack), 8'h01);
    foreach (exp[k]) begin
      rbyte(k != exp.size() - 1, d, st);
      chk({req, " data"}, d, exp[k]);
      chk({req, " R10 bit stable"}, 8'(st), 8'h01);
    end
    chk({req, " R7 released after NACK"}, 8'(sda_oe), 8'h00);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 led reset", led, 8'h01);
    chk("R1 sda released", 8'(sda_oe), 8'h00);
  endtask

  task automatic t_led_write();
    write_regs(8'h00, '{8'hA5}, "R4");
    chk("R4 led output", led, 8'hA5);
    read_from(8'h00, '{8'hA5}, "R4 readback");
  endtask

  task automatic t_consts();
    irq = 1'b1; mode = 4'hA; waitn(10);
    read_from(8'h01, '{8'h01, 8'h03, 8'h03, 8'h1A}, "R5 R6 R7 burst");
  endtask

  task automatic t_status_live();
    irq = 1'b0; mode = 4'h5; waitn(10);
    read_from(8'h04, '{8'h05}, "R6 live");
    irq = 1'b1; mode = 4'hF; waitn(10);
    read_from(8'h04, '{8'h1F}, "R6 live2");
  endtask

  task automatic t_bad_addr();
    logic ack;
    bus_start();
    wbyte(8'h62, ack); chk("R2 no ack other address", 8'(ack), 8'h00);
    wbyte(8'h00, ack); chk("R2 ignored byte", 8'(ack), 8'h00);
    wbyte(8'h77, ack); chk("R2 ignored byte2", 8'(ack), 8'h00);
    bus_stop();
    chk("R2 led unchanged", led, 8'hA5);
    bus_start();
    wbyte(8'h61 | 8'h80, ack); chk("R2 no ack read other", 8'(ack), 8'h00);
    bus_stop();
  endtask

  task automatic t_readonly();
    write_regs(8'h01, '{8'h55, 8'h66, 8'h77, 8'h88, 8'h99}, "R8 ro write");
    read_from(8'h01, '{8'h01, 8'h03, 8'h03}, "R8 ro unchanged");
    read_from(8'h05, '{8'h00, 8'h00}, "R8 high index zero");
    read_from(8'hFF, '{8'h00}, "R8 index ff zero");
    chk("R8 led untouched", led, 8'hA5);
  endtask

  task automatic t_autoinc();
    logic ack, st;
    logic [7:0] d;
    write_regs(8'h00, '{8'h3C, 8'h42}, "R3 autoinc");
    chk("R3 first data to index 0", led, 8'h3C);
    write_regs(8'h03, '{}, "R3 index only");
    bus_start();
    wbyte(8'h61, ack); chk("R3 read addr ack", 8'(ack), 8'h01);
    rbyte(1'b1, d, st); chk("R3 index kept", d, 8'h03);
    rbyte(1'b0, d, st); chk("R7 index advanced", d, 8'h1F);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    for (int i = 7; i >= 4; i--) send_bit(8'h60 >> i);
    bus_stop();
    chk("R9 idle after abort", 8'(sda_oe), 8'h00);
    bus_start();
    for (int i = 7; i >= 5; i--) send_bit(8'h62 >> i);
    bus_start();
    wbyte(8'h60, ack); chk("R9 restart ack", 8'(ack), 8'h01);
    bus_stop();
    read_from(8'h00, '{8'h3C}, "R9 after restart");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    waitn(10);
    rst = 1'b0;
    waitn(10);
    t_reset();
    t_led_write();
    t_consts();
    t_status_live();
    t_bad_addr();
    t_readonly();
    t_autoinc();
    t_abort();
    waitn(20);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule